// File: doc/BRIEF.md
# Farm-Road Intersection Light Controller

This block sequences the lamps at a crossing of a busy highway and a lightly used farm road. The highway keeps a green light by default. When a sensor reports a car waiting on the farm road, the controller first lets the highway green run for a minimum interval. It then steps the highway through yellow and gives the farm road green. Farm green is held while cars remain, up to a maximum interval. The farm road then goes through yellow and the highway becomes green again.

A single restartable interval timer times every phase. It has two thresholds, a short one for the yellow phases and a long one for the green phases, both counted in clock cycles. The controller restarts the timer on exactly the cycles on which it changes phase. Each road gets a 2-bit lamp code that is decoded directly from the controller phase. The block has no data stream: the sensor input and the lamp outputs are plain level signals with no handshake. The sensor is sampled on every clock edge and is assumed to be already synchronised and debounced.

Top module: `intersection_light_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, the highway lamp is green and the farm lamp is red. The timer leaves reset already past its long threshold.
- R2: The highway-green phase is left only when `car_waiting` is 1 and at least LONG_CYCLES clock edges have passed since the phase began. With the car held, the phase lasts exactly LONG_CYCLES+1 cycles. With no car it never ends.
- R3: The highway-yellow phase lasts exactly SHORT_CYCLES+1 cycles and is followed by farm green.
- R4: The farm-green phase ends at the first edge where `car_waiting` is 0, or else after exactly LONG_CYCLES+1 cycles when the car stays present. It is followed by farm yellow.
- R5: The farm-yellow phase lasts exactly SHORT_CYCLES+1 cycles and is followed by highway green.
- R6: The timer restarts on every phase change. A highway-green phase entered from farm yellow with a car already waiting still lasts LONG_CYCLES+1 cycles.
- R7: Lamp codes are 2'b00 red, 2'b01 yellow and 2'b10 green. Code 2'b11 never appears, and in every cycle at least one road shows red.
- R8: A car held on the farm road while its lamp is red sees a non-red farm lamp within 2*SHORT_CYCLES+LONG_CYCLES+3 cycles.
- R9: Changes of `car_waiting` during a yellow phase have no effect on that phase's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_waiting | input | 1 | Farm-road car sensor, 1 = car present |
| hwy_lamp | output | 2 | Highway lamp code (00 red, 01 yellow, 10 green) |
| farm_lamp | output | 2 | Farm-road lamp code (00 red, 01 yellow, 10 green) |

## Verification
The bench targets the off-by-one timing of every phase. A timer that compared one edge early or late would shorten or lengthen the yellow and green phases by one cycle against the SHORT_CYCLES+1 and LONG_CYCLES+1 counts. It sweeps the cycle on which the car leaves, from before the highway yellow through the whole farm green. A controller that ignored an empty road would hold farm green for the full long interval, and one that let the car cut a yellow short would break R9. It also holds the car through several full rounds. A timer not restarted on the return to highway green would hand the farm road green again after only one cycle, and one that hung in its counting phase would starve the waiting car and trip the bound of R8.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  // Lamp code as seen on the output pins (R7).
  typedef enum logic [1:0] {
    LAMP_RED   = 2'b00,
    LAMP_AMBER = 2'b01,
    LAMP_GREEN = 2'b10
  } lamp_e;

  // Controller phases; the order is the service rotation.
  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_e;

  // Interval timer progress.
  typedef enum logic [1:0] {
    TM_RUN   = 2'd0,
    TM_SHORT = 2'd1,
    TM_LONG  = 2'd2
  } tmr_e;

  localparam int unsigned NUM_ROADS = 2;

endpackage

// File: rtl/interval_timer.sv
module interval_timer
  import tlc_pkg::*;
#(
  parameter int unsigned SHORT_CYCLES = 4,
  parameter int unsigned LONG_CYCLES  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);

  localparam int unsigned CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYCLES);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYCLES);

  tmr_e          stage;
  logic [CW-1:0] elapsed;
  logic [CW-1:0] elapsed_nx;

  assign elapsed_nx = elapsed + CW'(1);

  // Advances on every edge it is not restarted, so it cannot stall
  // in the counting stage; saturates once the long mark is reached.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage   <= TM_LONG;
      elapsed <= LONG_V;
    end else if (restart) begin
      stage   <= TM_RUN;
      elapsed <= '0;
    end else if (stage != TM_LONG) begin
      elapsed <= elapsed_nx;
      if (elapsed_nx == LONG_V)       stage <= TM_LONG;
      else if (elapsed_nx == SHORT_V) stage <= TM_SHORT;
    end
  end

  assign short_done = (stage != TM_RUN);
  assign long_done  = (stage == TM_LONG);

  // R6: a restart always clears progress on the following cycle.
  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (stage == TM_RUN && elapsed == '0));

  // R6: the long expiry is sticky until the next restart.
  assert_long_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (long_done && !restart) |=> long_done);

  // R2: the long flag only rises when the full interval has elapsed.
  assert_long_at_limit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(long_done) |-> (elapsed == LONG_V));

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car_waiting,
  input  logic   short_done,
  input  logic   long_done,
  output phase_e phase,
  output logic   restart
);

  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_HWY_GO:    if (car_waiting && long_done)  phase_nx = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_done)                phase_nx = PH_FARM_GO;
      PH_FARM_GO:   if (!car_waiting || long_done) phase_nx = PH_FARM_WARN;
      PH_FARM_WARN: if (short_done)                phase_nx = PH_HWY_GO;
      default:                                     phase_nx = PH_HWY_GO;
    endcase
  end

  // Timer restart on exactly the cycles a phase change is taken.
  assign restart = (phase_nx != phase);

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_HWY_GO;
    else     phase <= phase_nx;
  end

  // R2: no farm car, highway green holds.
  assert_hwy_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HWY_GO && !car_waiting) |=> (phase == PH_HWY_GO));

  // R3: highway yellow holds until the short expiry.
  assert_hwy_warn_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HWY_WARN && !short_done) |=> (phase == PH_HWY_WARN));

  // R4: an empty farm road ends farm green on the next edge.
  assert_farm_empty_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FARM_GO && !car_waiting) |=> (phase == PH_FARM_WARN));

  // R5: farm yellow is followed by highway green.
  assert_farm_warn_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FARM_WARN && short_done) |=> (phase == PH_HWY_GO));

endmodule

// File: rtl/lamp_decoder.sv
module lamp_decoder
  import tlc_pkg::*;
#(
  parameter phase_e GO_PH   = PH_HWY_GO,
  parameter phase_e WARN_PH = PH_HWY_WARN
) (
  input  phase_e phase,
  output lamp_e  lamp
);

  always_comb begin
    if (phase == GO_PH)        lamp = LAMP_GREEN;
    else if (phase == WARN_PH) lamp = LAMP_AMBER;
    else                       lamp = LAMP_RED;
  end

endmodule

// File: rtl/intersection_light_ctrl.sv
module intersection_light_ctrl
  import tlc_pkg::*;
#(
  parameter int unsigned SHORT_CYCLES = 4,
  parameter int unsigned LONG_CYCLES  = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_waiting,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);

  phase_e phase;
  logic   restart;
  logic   short_done;
  logic   long_done;
  lamp_e  lamps [NUM_ROADS];

  interval_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .short_done(short_done),
    .long_done (long_done)
  );

  phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .car_waiting(car_waiting),
    .short_done (short_done),
    .long_done  (long_done),
    .phase      (phase),
    .restart    (restart)
  );

  // Road 0 is the highway, road 1 the farm road.
  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
    localparam phase_e GO_P   = (r == 0) ? PH_HWY_GO   : PH_FARM_GO;
    localparam phase_e WARN_P = (r == 0) ? PH_HWY_WARN : PH_FARM_WARN;
    lamp_decoder #(.GO_PH(GO_P), .WARN_PH(WARN_P)) u_dec (
      .phase(phase),
      .lamp (lamps[r])
    );
  end

  assign hwy_lamp  = lamps[0];
  assign farm_lamp = lamps[1];

  // R7: never both roads non-red.
  assert_one_red_R7: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp == LAMP_RED) || (farm_lamp == LAMP_RED));

  // R7: unused code never driven.
  assert_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp != 2'b11) && (farm_lamp != 2'b11));

endmodule

// File: tb/intersection_light_ctrl_test.sv
module intersection_light_ctrl_test;

  localparam int S = 2;
  localparam int L = 5;
  localparam int WAIT_BOUND = 2 * S + L + 3;
  localparam logic [1:0] RED = 2'b00, AMB = 2'b01, GRN = 2'b10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car = 1'b0;
  logic [1:0] hwy_lamp, farm_lamp;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  // Expected model: phase index and edges since the last phase change.
  int mph = 0;
  int mage = L;
  int waited = 0;

  always #10 clk = ~clk;

  intersection_light_ctrl #(.SHORT_CYCLES(S), .LONG_CYCLES(L)) uut (
    .clk(clk), .rst(rst), .car_waiting(car),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit go;
    cycles++;
    if (rst) begin
      mph = 0;
      mage = L;
    end else begin
      case (mph)
        0:       go = car && (mage >= L);
        1:       go = (mage >= S);
        2:       go = !car || (mage >= L);
        default: go = (mage >= S);
      endcase
      if (go) begin
        mph = (mph + 1) % 4;
        mage = 0;
      end else if (mage < L) begin
        mage++;
      end
    end
  end

  // Per-cycle comparison against the expected model.
  always @(negedge clk) begin
    if (running && !rst) begin
      logic [1:0] eh, ef;
      string tag;
      eh = (mph == 0) ? GRN : (mph == 1) ? AMB : RED;
      ef = (mph == 2) ? GRN : (mph == 3) ? AMB : RED;
      case (mph)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R4";
        default: tag = "R5";
      endcase
      chk(hwy_lamp == eh, {tag, " highway lamp"}, hwy_lamp, eh);
      chk(farm_lamp == ef, {tag, " farm lamp"}, farm_lamp, ef);
      chk((hwy_lamp == RED) || (farm_lamp == RED), "R7 one road red",
          {hwy_lamp, farm_lamp}, 0);
      chk((hwy_lamp != 2'b11) && (farm_lamp != 2'b11), "R7 legal code",
          {hwy_lamp, farm_lamp}, 0);
      if (car && farm_lamp == RED) waited++;
      else waited = 0;
      chk(waited <= WAIT_BOUND, "R8 waiting car served", waited, WAIT_BOUND);
    end
  end

  always @(posedge clk) begin
    if (!done && cycles > 20000) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic step(input bit c);
    @(negedge clk);
    #2 car = c;
  endtask

  initial begin
    int n;
    rst = 1'b1;
    car = 1'b0;
    repeat (3) @(negedge clk);
    chk(hwy_lamp == GRN, "R1 highway green in reset", hwy_lamp, GRN);
    chk(farm_lamp == RED, "R1 farm red in reset", farm_lamp, RED);
    #2 rst = 1'b0;
    running = 1'b1;
    @(negedge clk);
    chk(hwy_lamp == GRN, "R1 highway green after reset", hwy_lamp, GRN);
    #2;
    // R1: timer is past its long mark: a car leaves highway green at once.
    car = 1'b1;
    @(negedge clk);
    chk(hwy_lamp == AMB, "R1 timer long-done from reset", hwy_lamp, AMB);
    #2 car = 1'b0;

    // R2: no car keeps the highway green.
    repeat (20) step(1'b0);
    chk(hwy_lamp == GRN, "R2 idle highway green", hwy_lamp, GRN);

    // R4/R6/R8: car held through several rounds.
    repeat (40) step(1'b1);

    // R6: highway green entered with the car already waiting lasts L+1.
    while (hwy_lamp != RED) step(1'b1);
    while (hwy_lamp != GRN) step(1'b1);
    n = 0;
    while (hwy_lamp == GRN) begin n++; step(1'b1); end
    chk(n == L + 1, "R6 timer restart on return", n, L + 1);

    // R4: farm green held with a car lasts L+1.
    while (farm_lamp != GRN) step(1'b1);
    n = 0;
    while (farm_lamp == GRN) begin n++; step(1'b1); end
    chk(n == L + 1, "R4 farm green long expiry", n, L + 1);

    // R9: toggling the sensor during highway yellow keeps it S+1 long.
    step(1'b0);
    repeat (12) step(1'b0);
    while (hwy_lamp != AMB) step(1'b1);
    n = 0;
    while (hwy_lamp == AMB) begin n++; step(n[0]); end
    chk(n == S + 1, "R9 yellow length with sensor toggling", n, S + 1);
    repeat (15) step(1'b0);

    // Sweep of departure times.
    for (int d = 0; d < L + 2 * S + 6; d++) begin
      repeat (d) step(1'b1);
      repeat (15) step(1'b0);
    end

    // Exhaustive 4-bit sensor patterns, each repeated.
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 16; k++) step(p[k % 4]);
    end

    repeat (4) step(1'b0);
    running = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule